// File: doc/BRIEF.md
# Three-Bank Level Interrupt Controller

This block collects 96 level-sensitive interrupt lines, grouped in three banks of 32, and drives two processor requests: a normal request (`irq_o`) and a fast request (`fiq_o`). Software reaches it through a simple 32-bit register port with a 12-bit byte address. Reads are combinational and have no side effects. Writes take effect at the clock edge where `wr_en` is high.

Each line has three pieces of state: an input bit that follows the pin, a pending bit, and a mask bit. Software can also raise a line through a software-pending vector. Each line carries a 6-bit priority and a class bit that sends it to either the normal or the fast request. For each class, an arbiter picks the unmasked pending line with the lowest priority value. Ties go to the higher line number. The winning line number is latched as that class's vector code.

Once a request output goes high, it stays high until software re-arms that class through the control register. Re-arming drops the output at once, and the class is evaluated again on the next cycle. A global mask bit stops any new assertion.

Top module: `intc3_top`

## Requirements
- R1: After reset, every bank mask reads 0xFFFFFFFF, and the pending, software and input vectors are zero. Both outputs are low, both vector codes read 0, and every line register reads 0.
- R2: A line that goes from low to high sets its input bit and its pending bit. The raw view at bank offset +0x00 returns the input bits.
- R3: When any input of a bank drops, that bank's pending vector becomes its current inputs OR its software vector.
- R4: The bank view at +0x18 returns pending AND NOT mask AND NOT class. The view at +0x1C returns pending AND NOT mask AND class. Banks sit at 0x80 + 0x20×bank.
- R5: Writing +0x04 replaces the mask. Writing +0x08 clears the mask bits that are 1 in the data and triggers an evaluation, even when the data is zero. Writing +0x0C sets mask bits without triggering an evaluation. Offsets +0x08 and +0x0C read 0.
- R6: Writing +0x10 ORs the data into both the software vector (read at +0x10) and the pending vector, then triggers an evaluation. Writing +0x14 clears software bits and sets pending to software AND inputs. +0x14 reads 0.
- R7: The line register for line n is at 0x100 + 4n. Bits [7:2] hold the priority and bit 0 is the class: 1 routes the line to `fiq_o`, 0 routes it to `irq_o`.
- R8: For each class, the lowest priority value wins, and a tie goes to the highest line number. The winner is latched into 0x40 (normal) or 0x44 (fast).
- R9: An armed class asserts its output one cycle after an evaluation event, provided it has an unmasked pending line and the global mask is clear. Evaluation events are an input rise, a mask write, a mask-clear write, a software-set write and a re-arm. The class is then disarmed, and its output stays high.
- R10: In the control register at 0x48, writing bit 0 re-arms the normal class and writing bit 1 re-arms the fast class. Re-arming drops the output at that write, and the class is evaluated again on the next cycle.
- R11: Control bit 2 is the global mask. It blocks every new assertion and reads back at bit 2. Clearing it does not trigger an evaluation by itself.
- R12: Offset 0x00 reads 0x21, 0x14 reads 1 and 0x4C reads 0. Bank number 3 (0xE0–0xFF) and any undefined offset read 0 and ignore writes.
- R13: In the config register at 0x10, bit 0 is read/write. Writing bit 1 resets all state. The register at 0x50 holds two read/write bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| line_i | input | 96 | Level interrupt inputs, active high |
| wr_en | input | 1 | Register write strobe |
| addr | input | 12 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
Most internal faults show at the ports within one or two cycles, but only if software looks in the right place. A wrong pending or mask bit shows up at once in the pending views. It reaches a request output only at the next evaluation event.

A wrong arming flag is quieter. The output either fails to rise one cycle after an event, or it rises when no re-arm came first. For that reason the bench deliberately creates pending work without an event and checks that the output stays low. A wrong arbitration order shows up only in the latched vector code, so ties and priority changes are each followed by a re-arm and a read of the code.

// File: rtl/intc3_pkg.sv
package intc3_pkg;
   localparam int unsigned LINES_PER_BANK = 32;
   // register offsets inside a bank window, in word units
   localparam logic [2:0] BR_RAW  = 3'd0;
   localparam logic [2:0] BR_MASK = 3'd1;
   localparam logic [2:0] BR_MCLR = 3'd2;
   localparam logic [2:0] BR_MSET = 3'd3;
   localparam logic [2:0] BR_SSET = 3'd4;
   localparam logic [2:0] BR_SCLR = 3'd5;
   localparam logic [2:0] BR_PIRQ = 3'd6;
   localparam logic [2:0] BR_PFIQ = 3'd7;
   // global register byte offsets
   localparam logic [11:0] GA_REV   = 12'h000;
   localparam logic [11:0] GA_CFG   = 12'h010;
   localparam logic [11:0] GA_STAT  = 12'h014;
   localparam logic [11:0] GA_VIRQ  = 12'h040;
   localparam logic [11:0] GA_VFIQ  = 12'h044;
   localparam logic [11:0] GA_CTL   = 12'h048;
   localparam logic [11:0] GA_PROT  = 12'h04C;
   localparam logic [11:0] GA_IDLE  = 12'h050;
   localparam logic [11:0] GA_LINE0 = 12'h100;
endpackage

// File: rtl/intc3_bank.sv
module intc3_bank #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         srst,
   input  logic [W-1:0] line_i,
   input  logic         we_mask,
   input  logic         we_mclr,
   input  logic         we_mset,
   input  logic         we_sset,
   input  logic         we_sclr,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] inp_o,
   output logic [W-1:0] mask_o,
   output logic [W-1:0] pend_o,
   output logic [W-1:0] swi_o,
   output logic         rise_o
);
   logic [W-1:0] inp_q, mask_q, pend_q, swi_q;
   logic [W-1:0] rise, fall, pend_n, swi_n, mask_n;

   always_comb begin
      rise   = line_i & ~inp_q;
      fall   = inp_q & ~line_i;
      pend_n = pend_q | rise;
      if (|fall) pend_n = line_i | swi_q;
      swi_n  = swi_q;
      if (we_sset) begin
         swi_n  = swi_q | wdata;
         pend_n = pend_n | swi_n;
      end
      if (we_sclr) begin
         swi_n  = swi_q & ~wdata;
         pend_n = swi_n & line_i;
      end
      mask_n = mask_q;
      if (we_mask) mask_n = wdata;
      if (we_mclr) mask_n = mask_q & ~wdata;
      if (we_mset) mask_n = mask_q | wdata;
   end

   always_ff @(posedge clk) begin
      if (rst || srst) begin
         inp_q  <= '0;
         mask_q <= '1;
         pend_q <= '0;
         swi_q  <= '0;
      end else begin
         inp_q  <= line_i;
         mask_q <= mask_n;
         pend_q <= pend_n;
         swi_q  <= swi_n;
      end
   end

   assign inp_o  = inp_q;
   assign mask_o = mask_q;
   assign pend_o = pend_q;
   assign swi_o  = swi_q;
   assign rise_o = |rise;

   // R2: a rising line leaves its pending bit set
   a_r2_rise_sets_pending: assert property (@(posedge clk) disable iff (rst)
      (|(line_i & ~inp_q) && !we_sclr && !srst) |=>
      ((pend_q & $past(line_i & ~inp_q)) == $past(line_i & ~inp_q)));
   // R5: mask set only adds bits
   a_r5_mask_set_or: assert property (@(posedge clk) disable iff (rst)
      (we_mset && !srst) |=> (mask_q == ($past(mask_q) | $past(wdata))));
   // R6: software set keeps the written bits in both vectors
   a_r6_soft_set: assert property (@(posedge clk) disable iff (rst)
      (we_sset && !srst) |=> (((swi_q & pend_q) & $past(wdata)) == $past(wdata)));
endmodule

// File: rtl/intc3_arb.sv
module intc3_arb #(
   parameter int unsigned N  = 96,
   parameter int unsigned PW = 6,
   localparam int unsigned VW = $clog2(N)
) (
   input  logic [N-1:0]    req,
   input  logic [N*PW-1:0] prio,
   output logic            any_o,
   output logic [VW-1:0]   sel_o
);
   always_comb begin
      logic [PW-1:0] best;
      best  = '1;
      any_o = 1'b0;
      sel_o = '0;
      for (int i = 0; i < N; i++) begin
         if (req[i] && (!any_o || prio[i*PW +: PW] <= best)) begin
            best  = prio[i*PW +: PW];
            sel_o = VW'(i);
            any_o = 1'b1;
         end
      end
   end
endmodule

// File: rtl/intc3_top.sv
module intc3_top #(
   parameter int unsigned NB  = 3,
   parameter int unsigned LPB = 32,
   parameter int unsigned PW  = 6,
   parameter logic [7:0]  REV = 8'h21,
   localparam int unsigned NL = NB * LPB,
   localparam int unsigned VW = $clog2(NL)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [NL-1:0] line_i,
   input  logic          wr_en,
   input  logic [11:0]   addr,
   input  logic [31:0]   wdata,
   output logic [31:0]   rdata,
   output logic          irq_o,
   output logic          fiq_o
);
   import intc3_pkg::*;

   if (LPB != LINES_PER_BANK) begin : g_bad_lpb
      $error("intc3_top: LPB must be 32");
   end
   if (NB < 1 || NB > 3) begin : g_bad_nb
      $error("intc3_top: NB must be 1..3");
   end
   if (PW < 1 || PW > 6) begin : g_bad_pw
      $error("intc3_top: PW must be 1..6");
   end

   logic         srst, ctl_wr, gmask_q, autoidle_q;
   logic [1:0]   idle_q, rearm, out_q, agr_q, evq_q;
   logic [VW-1:0] vec_q [2];
   logic [PW-1:0] prio_q [NL];
   logic [NL-1:0] cls_q;
   logic [NL*PW-1:0] prio_flat;
   logic [NL-1:0] pend_all, mask_all;
   logic [31:0]  inp_b [NB], mask_b [NB], pend_b [NB], swi_b [NB];
   logic [NB-1:0] rise_b, evw_b;
   logic          is_bank, is_line, ev_common;
   logic [1:0]    bsel;
   logic [2:0]    breg;
   logic [11:0]   loff;
   logic [9:0]    lidx;

   assign is_bank = (addr[11:7] == 5'b00001);
   assign bsel    = addr[6:5];
   assign breg    = addr[4:2];
   assign loff    = addr - GA_LINE0;
   assign lidx    = loff[11:2];
   assign is_line = (addr >= GA_LINE0) && (lidx < 10'(NL));
   assign ctl_wr  = wr_en && (addr == GA_CTL);
   assign srst    = wr_en && (addr == GA_CFG) && wdata[1];
   assign rearm   = {ctl_wr & wdata[1], ctl_wr & wdata[0]};

   for (genvar b = 0; b < NB; b++) begin : g_bank
      logic sel;
      assign sel = wr_en && is_bank && (bsel == 2'(b));
      intc3_bank #(.W(LPB)) u_bank (
         .clk(clk), .rst(rst), .srst(srst),
         .line_i(line_i[b*LPB +: LPB]),
         .we_mask(sel && breg == BR_MASK), .we_mclr(sel && breg == BR_MCLR),
         .we_mset(sel && breg == BR_MSET), .we_sset(sel && breg == BR_SSET),
         .we_sclr(sel && breg == BR_SCLR), .wdata(wdata),
         .inp_o(inp_b[b]), .mask_o(mask_b[b]), .pend_o(pend_b[b]),
         .swi_o(swi_b[b]), .rise_o(rise_b[b]));
      assign evw_b[b] = sel && (breg == BR_MASK || breg == BR_MCLR || breg == BR_SSET);
      assign pend_all[b*LPB +: LPB] = pend_b[b];
      assign mask_all[b*LPB +: LPB] = mask_b[b];
   end
   assign ev_common = (|rise_b) || (|evw_b);

   for (genvar i = 0; i < NL; i++) begin : g_pf
      assign prio_flat[i*PW +: PW] = prio_q[i];
   end

   always_ff @(posedge clk) begin
      if (rst || srst) begin
         for (int i = 0; i < NL; i++) prio_q[i] <= '0;
         cls_q      <= '0;
         gmask_q    <= 1'b0;
         autoidle_q <= 1'b0;
         idle_q     <= '0;
      end else if (wr_en) begin
         if (is_line) begin
            prio_q[lidx[VW-1:0]] <= wdata[2 +: PW];
            cls_q[lidx[VW-1:0]]  <= wdata[0];
         end
         if (addr == GA_CTL)  gmask_q    <= wdata[2];
         if (addr == GA_CFG)  autoidle_q <= wdata[0];
         if (addr == GA_IDLE) idle_q     <= wdata[1:0];
      end
   end

   // class 0 drives irq_o, class 1 drives fiq_o
   for (genvar c = 0; c < 2; c++) begin : g_cls
      logic [NL-1:0] req;
      logic          any;
      logic [VW-1:0] sel;
      assign req = pend_all & ~mask_all & (c == 1 ? cls_q : ~cls_q);
      intc3_arb #(.N(NL), .PW(PW)) u_arb (
         .req(req), .prio(prio_flat), .any_o(any), .sel_o(sel));
      always_ff @(posedge clk) begin
         if (rst || srst) begin
            out_q[c] <= 1'b0;
            agr_q[c] <= 1'b1;
            evq_q[c] <= 1'b0;
            vec_q[c] <= '0;
         end else begin
            evq_q[c] <= ev_common || rearm[c];
            if (rearm[c]) begin
               out_q[c] <= 1'b0;
               agr_q[c] <= 1'b1;
            end else if (evq_q[c] && agr_q[c] && any && !gmask_q) begin
               out_q[c] <= 1'b1;
               agr_q[c] <= 1'b0;
               vec_q[c] <= sel;
            end
         end
      end
      // R9: an asserted output holds until re-armed
      a_r9_hold: assert property (@(posedge clk) disable iff (rst)
         (out_q[c] && !rearm[c] && !srst) |=> out_q[c]);
      // R10: re-arm drops the output at once
      a_r10_rearm_drop: assert property (@(posedge clk) disable iff (rst)
         rearm[c] |=> !out_q[c]);
      // R11: global mask keeps a low output low
      a_r11_gmask_block: assert property (@(posedge clk) disable iff (rst)
         (gmask_q && !out_q[c]) |=> !out_q[c]);
   end

   assign irq_o = out_q[0];
   assign fiq_o = out_q[1];

   always_comb begin
      rdata = '0;
      if (is_bank) begin
         if (bsel < 2'(NB)) begin
            case (breg)
               BR_RAW:  rdata = inp_b[bsel];
               BR_MASK: rdata = mask_b[bsel];
               BR_SSET: rdata = swi_b[bsel];
               BR_PIRQ: rdata = pend_b[bsel] & ~mask_b[bsel] & ~cls_q[bsel*LPB +: LPB];
               BR_PFIQ: rdata = pend_b[bsel] & ~mask_b[bsel] &  cls_q[bsel*LPB +: LPB];
               default: rdata = '0;
            endcase
         end
      end else if (is_line) begin
         rdata = {24'd0, 6'(prio_q[lidx[VW-1:0]]), 1'b0, cls_q[lidx[VW-1:0]]};
      end else begin
         case (addr)
            GA_REV:  rdata = {24'd0, REV};
            GA_CFG:  rdata = {31'd0, autoidle_q};
            GA_STAT: rdata = 32'd1;
            GA_VIRQ: rdata = 32'(vec_q[0]);
            GA_VFIQ: rdata = 32'(vec_q[1]);
            GA_CTL:  rdata = {29'd0, gmask_q, 2'b00};
            GA_IDLE: rdata = {30'd0, idle_q};
            default: rdata = '0;
         endcase
      end
   end
endmodule

// File: tb/intc3_top_tb.sv
module intc3_top_tb;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [95:0] ln = '0;
   logic        wr_en = 1'b0;
   logic [11:0] addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq_o, fiq_o;
   int checks = 0, errors = 0;
   bit done = 0;

   typedef struct {bit pin; logic [11:0] a; logic [31:0] e; string tag;} item_t;
   item_t q[$];

   always #4 clk = ~clk;

   intc3_top u_dut (.clk(clk), .rst(rst), .line_i(ln), .wr_en(wr_en), .addr(addr),
                    .wdata(wdata), .rdata(rdata), .irq_o(irq_o), .fiq_o(fiq_o));

   // monitor: pops expected items and compares at the falling edge
   always @(negedge clk) begin
      if (q.size() > 0) begin
         item_t it;
         logic [31:0] act;
         it  = q.pop_front();
         act = it.pin ? {30'd0, fiq_o, irq_o} : rdata;
         checks++;
         if (act !== it.e) begin
            errors++;
            $display("FAIL %s addr=%h actual=%h expected=%h", it.tag, it.a, act, it.e);
         end
      end
   end

   task automatic tick();
      @(posedge clk); #1;
   endtask
   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      addr = a; wdata = d; wr_en = 1'b1;
      tick();
      wr_en = 1'b0;
   endtask
   task automatic chk(input logic [11:0] a, input logic [31:0] e, input string tag);
      item_t it;
      addr = a;
      it.pin = 1'b0; it.a = a; it.e = e; it.tag = tag;
      q.push_back(it);
      tick();
   endtask
   task automatic chk_pins(input logic [1:0] e, input string tag);
      item_t it;
      it.pin = 1'b1; it.a = addr; it.e = {30'd0, e}; it.tag = tag;
      q.push_back(it);
      tick();
   endtask
   task automatic set_line(input int n, input logic v);
      ln[n] = v;
      tick();
   endtask

   initial begin
      repeat (3) tick();
      rst = 1'b0;
      // R1 reset state
      chk(12'h084, 32'hFFFF_FFFF, "R1 mask0");
      chk(12'h0C4, 32'hFFFF_FFFF, "R1 mask2");
      chk(12'h040, 32'd0, "R1 vec");
      chk_pins(2'b00, "R1 pins");
      // R12 constants
      chk(12'h000, 32'h21, "R12 rev");
      chk(12'h014, 32'd1, "R12 status");
      chk(12'h04C, 32'd0, "R12 prot");
      // R2 rise sets input, masked so no output
      set_line(5, 1'b1);
      chk(12'h080, 32'h20, "R2 raw");
      chk(12'h098, 32'd0, "R4 masked pirq");
      chk_pins(2'b00, "R9 masked no assert");
      // R5 mask clear evaluates
      wr(12'h088, 32'h20);
      chk(12'h084, 32'hFFFF_FFDF, "R5 mclr");
      chk(12'h088, 32'd0, "R5 mclr reads 0");
      chk_pins(2'b01, "R9 assert after mclr");
      chk(12'h098, 32'h20, "R4 pirq");
      chk(12'h09C, 32'd0, "R4 pfiq");
      chk(12'h040, 32'd5, "R8 vec 5");
      // R8 tie goes to higher line
      set_line(40, 1'b1);
      wr(12'h0A8, 32'h100);
      wr(12'h048, 32'h1);
      chk_pins(2'b00, "R10 rearm drops");
      chk_pins(2'b01, "R10 reassert");
      chk(12'h040, 32'd40, "R8 tie highest line");
      // R7 priority field
      wr(12'h1A0, 32'h0C);
      chk(12'h1A0, 32'h0C, "R7 line40 readback");
      wr(12'h048, 32'h1);
      tick();
      chk(12'h040, 32'd5, "R8 lower value wins");
      // R11 global mask
      wr(12'h048, 32'h5);
      tick();
      chk_pins(2'b00, "R11 blocked");
      chk(12'h048, 32'h4, "R11 readback");
      wr(12'h048, 32'h1);
      tick();
      chk_pins(2'b01, "R11 released");
      // R7 FIQ route, R4 views
      wr(12'h114, 32'h1);
      chk(12'h114, 32'h1, "R7 class bit");
      wr(12'h048, 32'h3);
      tick();
      chk_pins(2'b11, "R9 both asserted");
      chk(12'h044, 32'd5, "R8 fiq vec");
      chk(12'h040, 32'd40, "R8 irq vec");
      chk(12'h09C, 32'h20, "R4 pfiq bank0");
      chk(12'h098, 32'd0, "R4 pirq bank0");
      chk(12'h0B8, 32'h100, "R4 pirq bank1");
      // R3 input drop
      set_line(5, 1'b0);
      chk(12'h09C, 32'd0, "R3 drop clears");
      chk_pins(2'b11, "R9 fiq holds");
      // R6 software set/clear on bank 2
      wr(12'h0D0, 32'h3);
      chk(12'h0D0, 32'h3, "R6 swi readback");
      chk(12'h0C0, 32'd0, "R6 raw untouched");
      wr(12'h0C8, 32'h1);
      chk(12'h0D8, 32'h1, "R6 pend via swset");
      wr(12'h0D4, 32'h3);
      chk(12'h0D8, 32'd0, "R6 swclr pend");
      chk(12'h0D0, 32'd0, "R6 swclr swi");
      chk(12'h0D4, 32'd0, "R6 swclr reads 0");
      // R3 drop keeps software bits
      wr(12'h0C4, 32'h0);
      wr(12'h0D0, 32'h4);
      set_line(70, 1'b1);
      chk(12'h0D8, 32'h44, "R3 before drop");
      set_line(70, 1'b0);
      chk(12'h0D8, 32'h4, "R3 swi kept");
      // R11 clear without event, R5 mask set no evaluation
      wr(12'h048, 32'h5);
      tick();
      chk_pins(2'b10, "R11 irq dropped");
      wr(12'h048, 32'h0);
      tick();
      chk_pins(2'b10, "R11 clear no eval");
      wr(12'h0AC, 32'h0);
      tick();
      chk_pins(2'b10, "R5 mset no eval");
      chk(12'h0AC, 32'd0, "R5 mset reads 0");
      wr(12'h0A8, 32'h0);
      tick();
      chk_pins(2'b11, "R5 mclr zero evaluates");
      // R12 bank 3 and undefined offsets
      wr(12'h0E4, 32'h0);
      chk(12'h0E4, 32'd0, "R12 bank3 read");
      chk(12'h084, 32'hFFFF_FFDF, "R12 bank3 write ignored");
      wr(12'h27C, 32'hFD);
      chk(12'h27C, 32'hFD, "R7 last line");
      wr(12'h280, 32'hFF);
      chk(12'h280, 32'd0, "R12 past last line");
      wr(12'h020, 32'hFF);
      chk(12'h020, 32'd0, "R12 undefined");
      // R13 config and idle
      wr(12'h050, 32'h3);
      chk(12'h050, 32'h3, "R13 idle");
      wr(12'h010, 32'h1);
      chk(12'h010, 32'h1, "R13 autoidle");
      wr(12'h010, 32'h2);
      chk(12'h084, 32'hFFFF_FFFF, "R13 reset mask");
      chk(12'h050, 32'd0, "R13 reset idle");
      chk(12'h010, 32'd0, "R13 reset cfg");
      chk(12'h1A0, 32'd0, "R13 reset line reg");
      chk_pins(2'b00, "R13 reset pins");
      while (q.size() > 0) tick();
      if (!done) begin
         done = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++; errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule